// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects one-cycle event pulses from seven interrupt sources of a peripheral interface chip, latches each into a pending flag, and masks the flags with a per-source enable bit. If any pending flag is also enabled, the block pulls its active-low interrupt request output low. A processor reaches the block through a 4-bit register select, a chip select, a read/write strobe and an 8-bit data bus. The flag register sits at select 13 and the enable register at select 14.

A processor write can clear individual flags without touching the others. The enable register is changed selectively: data bit 7 of the write decides whether the ones in bits 6..0 set or clear their enable bits. Each flag can also be cleared by a side-effect strobe that the surrounding port logic raises, for example on an access to an output register. The top bit of the flag register is not stored. It is the live summary of pending enabled interrupts, so a read of it shows the state of the request line.

Top module: `irq_unit`

## Requirements
- R1: After a synchronous reset every flag and every enable bit is 0. The flag register reads 0x00, the enable register reads 0x80, and irq_n is 1.
- R2: An event pulse on evt_set[i] for one cycle sets flag i at that clock edge. The flag is visible on the next read.
- R3: A write (cs=1, rw=0) to select 13 clears flag i for each 1 in data bit i (bits 6..0). Zeros leave flags unchanged, and data bit 7 has no effect.
- R4: A pulse on side_clr[i] clears flag i at that clock edge.
- R5: When evt_set[i] is high in the same cycle as a write-clear or a side clear of flag i, the flag ends up set.
- R6: A write to select 14 with data bit 7 = 1 sets enable bit i for each 1 in data bits 6..0. The other enable bits keep their value.
- R7: A write to select 14 with data bit 7 = 0 clears enable bit i for each 1 in data bits 6..0. The other enable bits keep their value. No other access changes the enable bits.
- R8: A read (cs=1, rw=1) of select 14 returns the enable bits in bits 6..0, with bit 7 always 1.
- R9: A read of select 13 returns the flags in bits 6..0. Bit 7 is the OR over i of (flag i AND enable i).
- R10: irq_n is 0 exactly when some flag is set together with its enable bit. It follows the registers without extra delay.
- R11: rdata_oe is 1, and rdata non-zero is possible, only for a read with cs=1 of select 13 or 14. Otherwise rdata_oe and rdata are 0. Writes take effect only with cs=1 and rw=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 4 | Register select |
| wdata | input | 8 | Write data |
| evt_set | input | 7 | Per-source event pulses |
| side_clr | input | 7 | Per-source side-effect clear strobes |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | High while this block drives rdata |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The key overlap is a source event landing in the same cycle as a clear of the same flag. The clear can come from a processor write to the flag register, from a side-effect strobe, or from both at once. Directed steps raise all three on one bit together, then read the flag back and expect it to be set. A long random phase draws event, clear strobe and bus inputs independently every cycle, so such overlaps, as well as overlaps with enable writes, happen often. A behavioural model in the bench judges every cycle's read data, drive enable and request line.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W = 8;
    localparam int NSRC   = DATA_W - 1;
    localparam int RS_W   = 4;
    localparam logic [RS_W-1:0] SEL_FLAGS  = 4'd13;
    localparam logic [RS_W-1:0] SEL_ENABLE = 4'd14;

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RD_FLAGS,
        ACC_RD_ENABLE,
        ACC_WR_FLAGS,
        ACC_WR_ENABLE
    } access_e;

    typedef struct packed {
        access_e  kind;
        src_vec_t mask;
        logic     set_mode;
    } bus_op_t;

    function automatic src_vec_t apply_mask(src_vec_t cur, src_vec_t mask, logic set_mode);
        return set_mode ? (cur | mask) : (cur & ~mask);
    endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pkg::*;
(
    input  logic            cs,
    input  logic            rw,
    input  logic [RS_W-1:0] rs,
    input  data_t           wdata,
    output bus_op_t         op
);
    always_comb begin
        op.kind     = ACC_NONE;
        op.mask     = wdata[NSRC-1:0];
        op.set_mode = wdata[DATA_W-1];
        if (cs) begin
            if (rs == SEL_FLAGS)
                op.kind = rw ? ACC_RD_FLAGS : ACC_WR_FLAGS;
            else if (rs == SEL_ENABLE)
                op.kind = rw ? ACC_RD_ENABLE : ACC_WR_ENABLE;
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_op_t  op,
    input  src_vec_t evt_set,
    input  src_vec_t side_clr,
    output src_vec_t flag_q
);
    src_vec_t clr_vec;

    always_comb begin
        clr_vec = side_clr;
        if (op.kind == ACC_WR_FLAGS)
            clr_vec = clr_vec | op.mask;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (evt_set[i])
                flag_q[i] <= 1'b1;
            else if (clr_vec[i])
                flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_op_t  op,
    output src_vec_t en_q
);
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (op.kind == ACC_WR_ENABLE)
            en_q <= apply_mask(en_q, op.mask, op.set_mode);
    end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cs,
    input  logic            rw,
    input  logic [RS_W-1:0] rs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0] evt_set,
    input  logic [NSRC-1:0] side_clr,
    output logic [DATA_W-1:0] rdata,
    output logic            rdata_oe,
    output logic            irq_n
);
    bus_op_t  op;
    src_vec_t flag_q;
    src_vec_t en_q;
    logic     summary;

    irq_bus_decode u_dec (
        .cs(cs), .rw(rw), .rs(rs), .wdata(wdata), .op(op)
    );

    irq_flag_bank u_flags (
        .clk(clk), .rst(rst), .op(op),
        .evt_set(evt_set), .side_clr(side_clr), .flag_q(flag_q)
    );

    irq_enable_bank u_enables (
        .clk(clk), .rst(rst), .op(op), .en_q(en_q)
    );

    assign summary = |(flag_q & en_q);
    assign irq_n   = ~summary;

    always_comb begin
        rdata    = '0;
        rdata_oe = 1'b0;
        unique case (op.kind)
            ACC_RD_FLAGS: begin
                rdata    = {summary, flag_q};
                rdata_oe = 1'b1;
            end
            ACC_RD_ENABLE: begin
                rdata    = {1'b1, en_q};
                rdata_oe = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_unit_checker.sv
module irq_unit_checker
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cs,
    input logic            rw,
    input logic [RS_W-1:0] rs,
    input logic [NSRC-1:0] evt_set,
    input logic [NSRC-1:0] side_clr,
    input logic [DATA_W-1:0] rdata,
    input logic            rdata_oe,
    input logic            irq_n,
    input logic [NSRC-1:0] flag_q,
    input logic [NSRC-1:0] en_q
);
    logic rd_hit;
    assign rd_hit = cs && rw && (rs == SEL_FLAGS || rs == SEL_ENABLE);

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_set != '0) |=> ((flag_q & $past(evt_set)) == $past(evt_set))); // R5

    AST_SIDE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((side_clr & ~evt_set) != '0) |=> ((flag_q & $past(side_clr & ~evt_set)) == '0)); // R4

    AST_EN_HELD: assert property (@(posedge clk) disable iff (rst)
        !(cs && !rw && rs == SEL_ENABLE) |=> $stable(en_q)); // R7

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        irq_n == ((flag_q & en_q) == '0)); // R10

    AST_ENABLE_TOPBIT: assert property (@(posedge clk) disable iff (rst)
        (cs && rw && rs == SEL_ENABLE) |-> (rdata_oe && rdata[DATA_W-1])); // R8

    AST_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (!rdata_oe && rdata == '0)); // R11

    AST_FLAG_NOT_RAISED: assert property (@(posedge clk) disable iff (rst)
        (evt_set == '0) |=> ((flag_q & ~$past(flag_q)) == '0)); // R2
endmodule

bind irq_unit irq_unit_checker u_chk (
    .clk(clk), .rst(rst), .cs(cs), .rw(rw), .rs(rs),
    .evt_set(evt_set), .side_clr(side_clr),
    .rdata(rdata), .rdata_oe(rdata_oe), .irq_n(irq_n),
    .flag_q(flag_q), .en_q(en_q)
);

// File: tb/irq_unit_bench.sv
module irq_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs, rw;
    logic [3:0] rs;
    logic [7:0] wdata;
    logic [6:0] evt_set, side_clr;
    logic [7:0] rdata;
    logic       rdata_oe, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0] m_flag, m_en;
    logic [7:0] got_rd;
    logic       got_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_unit u_irq_unit (
        .clk(clk), .rst(rst), .cs(cs), .rw(rw), .rs(rs), .wdata(wdata),
        .evt_set(evt_set), .side_clr(side_clr),
        .rdata(rdata), .rdata_oe(rdata_oe), .irq_n(irq_n)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, compare against the behavioural model, then advance it.
    task automatic step(logic c, logic r, logic [3:0] s, logic [7:0] d,
                        logic [6:0] ev, logic [6:0] sc);
        logic [7:0] exp_rd;
        logic       exp_oe;
        logic       pend;
        @(negedge clk);
        cs = c; rw = r; rs = s; wdata = d; evt_set = ev; side_clr = sc;
        #1;
        pend   = (m_flag & m_en) != 0;
        exp_rd = 8'h00;
        exp_oe = 1'b0;
        if (c && r && s == 4'd13) begin exp_rd = {pend, m_flag}; exp_oe = 1; end
        if (c && r && s == 4'd14) begin exp_rd = {1'b1, m_en};   exp_oe = 1; end
        got_rd  = rdata;
        got_irq = irq_n;
        if (s == 4'd13 && c && r)      check("R9 rdata", rdata, exp_rd);
        else if (s == 4'd14 && c && r) check("R8 rdata", rdata, exp_rd);
        else                           check("R11 rdata", rdata, exp_rd);
        check("R11 rdata_oe", rdata_oe, exp_oe);
        check("R10 irq_n", irq_n, !pend);
        @(posedge clk);
        for (int i = 0; i < 7; i++) begin
            if (ev[i]) m_flag[i] = 1'b1;
            else if (sc[i] || (c && !r && s == 4'd13 && d[i])) m_flag[i] = 1'b0;
        end
        if (c && !r && s == 4'd14) begin
            if (d[7]) m_en = m_en | d[6:0];
            else      m_en = m_en & ~d[6:0];
        end
    endtask

    task automatic idle();
        step(0, 1, 4'd0, 8'h00, 7'h00, 7'h00);
    endtask

    initial begin
        rst = 1; cs = 0; rw = 1; rs = 0; wdata = 0; evt_set = 0; side_clr = 0;
        m_flag = 0; m_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        step(1, 1, 4'd13, 8'h00, 7'h00, 7'h00); check("R1 flags", got_rd, 8'h00);
        check("R1 irq_n", got_irq, 1'b1);
        step(1, 1, 4'd14, 8'h00, 7'h00, 7'h00); check("R1 enables", got_rd, 8'h80);

        // R2 event sets flags
        step(0, 1, 4'd0, 8'h00, 7'h05, 7'h00);
        step(1, 1, 4'd13, 8'h00, 7'h00, 7'h00); check("R2 flags", got_rd, 8'h05);

        // R6 enable set, then R9/R10 summary
        step(1, 0, 4'd14, 8'h81, 7'h00, 7'h00);
        step(1, 1, 4'd14, 8'h00, 7'h00, 7'h00); check("R6 enables", got_rd, 8'h81);
        step(1, 1, 4'd13, 8'h00, 7'h00, 7'h00); check("R9 flags", got_rd, 8'h85);
        check("R10 irq low", got_irq, 1'b0);

        // R3 write-clear, bit 7 ignored
        step(1, 0, 4'd13, 8'h81, 7'h00, 7'h00);
        step(1, 1, 4'd13, 8'h00, 7'h00, 7'h00); check("R3 flags", got_rd, 8'h04);
        check("R10 irq high", got_irq, 1'b1);

        // R4 side clear
        step(0, 1, 4'd0, 8'h00, 7'h00, 7'h04);
        step(1, 1, 4'd13, 8'h00, 7'h00, 7'h00); check("R4 flags", got_rd, 8'h00);

        // R5 set wins over both clears at once
        step(1, 0, 4'd13, 8'h02, 7'h02, 7'h02);
        step(1, 1, 4'd13, 8'h00, 7'h00, 7'h00); check("R5 flags", got_rd, 8'h02);

        // R7 selective clear of enables
        step(1, 0, 4'd14, 8'hFF, 7'h00, 7'h00);
        step(1, 0, 4'd14, 8'h01, 7'h00, 7'h00);
        step(1, 1, 4'd14, 8'h00, 7'h00, 7'h00); check("R7 enables", got_rd, 8'hFE);

        // R11 unselected read, deselected write
        step(1, 1, 4'd5, 8'h00, 7'h00, 7'h00); check("R11 other rs", got_rd, 8'h00);
        step(0, 0, 4'd14, 8'h7F, 7'h00, 7'h00);
        step(0, 0, 4'd13, 8'h7F, 7'h00, 7'h00);
        step(1, 1, 4'd14, 8'h00, 7'h00, 7'h00); check("R11 cs gates enable write", got_rd, 8'hFE);
        step(1, 1, 4'd13, 8'h00, 7'h00, 7'h00); check("R11 cs gates flag write", got_rd, 8'h82);
        idle();

        // random phase: model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] s;
            logic [6:0] ev, sc;
            s  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                             : (($urandom_range(0, 1) == 1) ? 4'd13 : 4'd14);
            ev = ($urandom_range(0, 2) == 0) ? 7'($urandom) : 7'h00;
            sc = ($urandom_range(0, 2) == 0) ? 7'($urandom) : 7'h00;
            step(1'($urandom_range(0, 4) != 0), 1'($urandom), s, 8'($urandom), ev, sc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule